// File: doc/BRIEF.md
# Sound Generator Voice: Oscillator, Envelope and Stereo Pan

This block is a single voice of a programmable sound generator. It takes an eight-byte configuration record, a sample-rate tick and a gate, and it returns one signed sample for the left channel and one for the right. A 16-bit phase accumulator drives one of four wave shapes. A duty byte shapes every one of those waveforms.

A four-phase envelope sets the voice's attenuation. The phases are idle, attack, decay and release. Attack moves toward its target, then decay moves toward a second target and holds there while the gate is high. Release returns the voice to silence. A signed pan value then divides the attenuated sample linearly between the two outputs.

Eight copies of this block make a full generator. Mixing the voices and producing the audio output happen outside it.

Top module: `psg_voice`

## Requirements
- R1: While rst_ni is low, left_o and right_o are 0. The envelope starts idle at full attenuation (15).
- R2: On every cycle with tick_i high, the 16-bit phase advances by the frequency word (bytes 0–1 of cfg_i, little-endian) modulo 2^16. Without a tick, the phase holds.
- R3: The wave shape is chosen by bits 1:0 of byte 6, with ph = phase[15:8]. The shapes are: 0 square (+127), 1 rising ramp (ph−128), 2 triangle (2t−128, where t = ph for ph<128 and 255−ph otherwise), 3 falling ramp (127−ph).
- R4: The duty byte is byte 2. When ph < duty, the shape value is used. Otherwise the square wave gives −128 and every other shape gives 0. A duty of 0 therefore silences shapes 1–3 and holds the square low.
- R5: The attack byte is byte 3 and the decay byte is byte 4. In each, bits 7:4 are the target attenuation and bits 3:0 are the rate. Byte 7, bits 7:2 of byte 6 and bit 7 of byte 5 have no effect.
- R6: A rising gate enters attack. The rate reload counter is loaded with 15−rate, so a step happens once every 16−rate ticks. Each step moves the attenuation by exactly 1 toward the target. Without a tick, the attenuation does not change.
- R7: On the first tick at which the attack target is reached, the envelope enters decay. Decay steps toward the decay target at the decay rate and then holds for as long as the gate stays high.
- R8: A falling gate enters release. Release steps toward 15 at the decay rate and then goes idle. Idle always means attenuation 15.
- R9: The amplitude is (sample × (15 − attenuation)) >>> 4. At attenuation 15 both outputs are 0.
- R10: Pan is a signed 7-bit value in byte 5, bits 6:0. left = (a × (64 − pan)) >>> 7 and right = (a × (64 + pan)) >>> 7. With pan 0 the two outputs are equal.
- R11: The outputs are registered. They reflect the phase, envelope and configuration of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample-rate strobe, one cycle wide |
| gate_i | input | 1 | Note gate; its edges start attack and release |
| cfg_i | input | 64 | Configuration record; byte k is bits 8k+7:8k |
| left_o | output | 8 | Signed left-channel sample |
| right_o | output | 8 | Signed right-channel sample |

## Verification
Some properties are checked by assertions on every cycle:
- the phase holds between ticks and advances by exactly the frequency word on a tick;
- the attenuation changes only on a tick and by at most one unit;
- idle implies full attenuation, and full attenuation produces zero outputs one cycle later;
- a centred pan produces equal outputs.

Other behaviour can only be shown by the bench's scenarios, compared against a behavioural model on every clock:
- the exact step interval for each rate;
- the attack-to-decay handover;
- release followed by a retrigger;
- the wave shapes under duty 0, 255 and intermediate values;
- the pan extremes;
- the padding bits having no effect.

// File: rtl/psg_pkg.sv
package psg_pkg;
  typedef enum logic [1:0] {
    ENV_IDLE    = 2'd0,
    ENV_ATTACK  = 2'd1,
    ENV_DECAY   = 2'd2,
    ENV_RELEASE = 2'd3
  } env_st_e;
endpackage

// File: rtl/psg_phase.sv
module psg_phase #(
  parameter int PHASE_W = 16,
  parameter int SMP_W   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [PHASE_W-1:0]      freq_i,
  input  logic [SMP_W-1:0]        duty_i,
  input  logic [1:0]              wave_i,
  output logic [PHASE_W-1:0]      phase_o,
  output logic signed [SMP_W-1:0] smp_o
);
  localparam logic [SMP_W-1:0] S_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] S_MIN = {1'b1, {(SMP_W-1){1'b0}}};

  logic [PHASE_W-1:0] phase_q;
  logic [SMP_W-1:0]   ph, base;
  logic [SMP_W-2:0]   tri_t;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (tick_i) phase_q <= phase_q + freq_i;
  end

  always_comb begin
    ph    = phase_q[PHASE_W-1 -: SMP_W];
    tri_t = ph[SMP_W-1] ? ~ph[SMP_W-2:0] : ph[SMP_W-2:0];
    case (wave_i)
      2'd0:    base = S_MAX;
      2'd1:    base = {~ph[SMP_W-1], ph[SMP_W-2:0]};
      2'd2:    base = {~tri_t[SMP_W-2], tri_t[SMP_W-3:0], 1'b0};
      default: base = {ph[SMP_W-1], ~ph[SMP_W-2:0]};
    endcase
    // pulse-width shaping: outside the duty window square goes low, others mute
    if (ph < duty_i)        smp_o = base;
    else if (wave_i == 2'd0) smp_o = S_MIN;
    else                     smp_o = '0;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/psg_env.sv
module psg_env
  import psg_pkg::*;
#(
  parameter int ATT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic [ATT_W-1:0] atk_lvl_i,
  input  logic [ATT_W-1:0] atk_rate_i,
  input  logic [ATT_W-1:0] dcy_lvl_i,
  input  logic [ATT_W-1:0] dcy_rate_i,
  output logic [ATT_W-1:0] att_o,
  output env_st_e          st_o
);
  localparam logic [ATT_W-1:0] ATT_MAX = '1;

  env_st_e          st_q;
  logic [ATT_W-1:0] att_q, cnt_q, tgt, rate;
  logic             gate_q, rise, fall;

  assign rise = gate_i & ~gate_q;
  assign fall = ~gate_i & gate_q;

  always_comb begin
    case (st_q)
      ENV_ATTACK: begin tgt = atk_lvl_i; rate = atk_rate_i; end
      ENV_DECAY:  begin tgt = dcy_lvl_i; rate = dcy_rate_i; end
      default:    begin tgt = ATT_MAX;   rate = dcy_rate_i; end
    endcase
  end

  // reload = max - rate: higher rate -> shorter interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ENV_IDLE;
      att_q  <= ATT_MAX;
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (rise) begin
        st_q  <= ENV_ATTACK;
        cnt_q <= ~atk_rate_i;
      end else if (fall) begin
        st_q  <= ENV_RELEASE;
        cnt_q <= ~dcy_rate_i;
      end else if (tick_i && st_q != ENV_IDLE) begin
        if (att_q == tgt) begin
          if (st_q == ENV_ATTACK) begin
            st_q  <= ENV_DECAY;
            cnt_q <= ~dcy_rate_i;
          end else if (st_q == ENV_RELEASE) begin
            st_q <= ENV_IDLE;
          end
        end else if (cnt_q == '0) begin
          att_q <= (att_q < tgt) ? att_q + 1'b1 : att_q - 1'b1;
          cnt_q <= ~rate;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign att_o = att_q;
  assign st_o  = st_q;
endmodule

// File: rtl/psg_pan.sv
module psg_pan #(
  parameter int SMP_W = 8,
  parameter int ATT_W = 4,
  parameter int PAN_W = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic [ATT_W-1:0]        att_i,
  input  logic signed [PAN_W-1:0] pan_i,
  output logic signed [SMP_W-1:0] left_o,
  output logic signed [SMP_W-1:0] right_o
);
  localparam int AW = SMP_W + ATT_W + 1;
  localparam int WW = PAN_W + 2;
  localparam int PW = SMP_W + WW;
  localparam logic [ATT_W-1:0]     ATT_MAX = '1;
  localparam logic signed [WW-1:0] CTR     = WW'(2 ** (PAN_W - 1));

  logic [ATT_W-1:0]        gain;
  logic signed [AW-1:0]    smp_x, gain_x, amp_p;
  logic signed [SMP_W-1:0] amp, left_d, right_d;
  logic signed [WW-1:0]    pan_x, wl, wr;
  logic signed [PW-1:0]    amp_x, wl_x, wr_x, pl, pr;

  always_comb begin
    gain    = ATT_MAX - att_i;
    smp_x   = {{(ATT_W+1){smp_i[SMP_W-1]}}, smp_i};
    gain_x  = {{(SMP_W+1){1'b0}}, gain};
    amp_p   = smp_x * gain_x;
    amp     = SMP_W'(amp_p >>> ATT_W);
    pan_x   = {{2{pan_i[PAN_W-1]}}, pan_i};
    wl      = CTR - pan_x;
    wr      = CTR + pan_x;
    amp_x   = {{WW{amp[SMP_W-1]}}, amp};
    wl_x    = {{SMP_W{wl[WW-1]}}, wl};
    wr_x    = {{SMP_W{wr[WW-1]}}, wr};
    pl      = amp_x * wl_x;
    pr      = amp_x * wr_x;
    left_d  = SMP_W'(pl >>> PAN_W);
    right_d = SMP_W'(pr >>> PAN_W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o  <= '0;
      right_o <= '0;
    end else begin
      left_o  <= left_d;
      right_o <= right_d;
    end
  end
endmodule

// File: rtl/psg_voice.sv
module psg_voice
  import psg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic [63:0]       cfg_i,
  output logic signed [7:0] left_o,
  output logic signed [7:0] right_o
);
  localparam int PHASE_W = 16;
  localparam int SMP_W   = 8;
  localparam int ATT_W   = 4;
  localparam int PAN_W   = 7;

  logic [PHASE_W-1:0]      freq, phase;
  logic [SMP_W-1:0]        duty;
  logic [1:0]              wave;
  logic [ATT_W-1:0]        atk_lvl, atk_rate, dcy_lvl, dcy_rate, att;
  logic signed [PAN_W-1:0] pan;
  logic signed [SMP_W-1:0] smp;
  env_st_e                 env_st;
  logic                    unused_cfg;

  // record: freq lo/hi, duty, attack, decay, pan, wave, pad
  assign freq       = cfg_i[15:0];
  assign duty       = cfg_i[23:16];
  assign atk_lvl    = cfg_i[31:28];
  assign atk_rate   = cfg_i[27:24];
  assign dcy_lvl    = cfg_i[39:36];
  assign dcy_rate   = cfg_i[35:32];
  assign pan        = cfg_i[46:40];
  assign wave       = cfg_i[49:48];
  assign unused_cfg = ^{cfg_i[63:50], cfg_i[47]};

  psg_phase #(.PHASE_W(PHASE_W), .SMP_W(SMP_W)) u_phase (
    .clk_i, .rst_ni, .tick_i,
    .freq_i(freq), .duty_i(duty), .wave_i(wave),
    .phase_o(phase), .smp_o(smp)
  );

  psg_env #(.ATT_W(ATT_W)) u_env (
    .clk_i, .rst_ni, .tick_i, .gate_i,
    .atk_lvl_i(atk_lvl), .atk_rate_i(atk_rate),
    .dcy_lvl_i(dcy_lvl), .dcy_rate_i(dcy_rate),
    .att_o(att), .st_o(env_st)
  );

  psg_pan #(.SMP_W(SMP_W), .ATT_W(ATT_W), .PAN_W(PAN_W)) u_pan (
    .clk_i, .rst_ni,
    .smp_i(smp), .att_i(att), .pan_i(pan),
    .left_o, .right_o
  );
endmodule

// File: rtl/psg_voice_chk.sv
module psg_voice_chk
  import psg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [63:0]       cfg_i,
  input logic [15:0]       phase_i,
  input logic [3:0]        att_i,
  input env_st_e           st_i,
  input logic signed [7:0] left_i,
  input logic signed [7:0] right_i
);
  p_phase_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_i));

  p_phase_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> phase_i == 16'($past(phase_i) + $past(cfg_i[15:0])));

  p_att_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(att_i));

  p_att_unit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (att_i == $past(att_i)) || (att_i == $past(att_i) + 4'd1)
               || (att_i == $past(att_i) - 4'd1));

  p_idle_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ENV_IDLE |-> att_i == 4'hF);

  p_mute_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_i == 4'hF |=> left_i == 8'sd0 && right_i == 8'sd0);

  p_pan_centre_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[46:40] == 7'd0 |=> left_i == right_i);
endmodule

bind psg_voice psg_voice_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cfg_i(cfg_i),
  .phase_i(phase), .att_i(att), .st_i(env_st),
  .left_i(left_o), .right_i(right_o)
);

// File: tb/sim_psg_voice.sv
`timescale 1ns/1ps
module sim_psg_voice;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic              gate_i = 1'b0;
  logic [63:0]       cfg_i = '0;
  logic signed [7:0] left_o, right_o;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    tick_en = 1'b0;
  int    div = 0;

  // reference model state
  int m_ph = 0, m_att = 15, m_st = 0, m_cnt = 0, m_l = 0, m_r = 0;
  bit m_gq = 1'b0;

  always #5 clk_i = ~clk_i;

  psg_voice u0 (.clk_i, .rst_ni, .tick_i, .gate_i, .cfg_i, .left_o, .right_o);

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int shape(int ph, int duty, int w);
    int t;
    if (ph < duty) begin
      t = (ph < 128) ? ph : 255 - ph;
      case (w)
        0: return 127;
        1: return ph - 128;
        2: return 2 * t - 128;
        default: return 127 - ph;
      endcase
    end
    return (w == 0) ? -128 : 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin : model
    int freq, duty, al, ar, dl, dr, p, w, s, a, tgt, rt;
    bit rise, fall;
    if (!rst_ni) begin
      m_ph = 0; m_att = 15; m_st = 0; m_cnt = 0; m_gq = 0; m_l = 0; m_r = 0;
    end else begin
      freq = int'(cfg_i[15:0]);  duty = int'(cfg_i[23:16]);
      al = int'(cfg_i[31:28]);   ar = int'(cfg_i[27:24]);
      dl = int'(cfg_i[39:36]);   dr = int'(cfg_i[35:32]);
      p  = int'(cfg_i[46:40]);   if (p >= 64) p -= 128;
      w  = int'(cfg_i[49:48]);
      s  = shape(m_ph / 256, duty, w);
      a  = (s * (15 - m_att)) >>> 4;
      m_l = (a * (64 - p)) >>> 7;
      m_r = (a * (64 + p)) >>> 7;
      rise = gate_i && !m_gq;
      fall = !gate_i && m_gq;
      if (rise) begin
        m_st = 1; m_cnt = 15 - ar;
      end else if (fall) begin
        m_st = 3; m_cnt = 15 - dr;
      end else if (tick_i && m_st != 0) begin
        tgt = (m_st == 1) ? al : (m_st == 2) ? dl : 15;
        rt  = (m_st == 1) ? ar : dr;
        if (m_att == tgt) begin
          if (m_st == 1) begin m_st = 2; m_cnt = 15 - dr; end
          else if (m_st == 3) m_st = 0;
        end else if (m_cnt == 0) begin
          m_att += (m_att < tgt) ? 1 : -1;
          m_cnt = 15 - rt;
        end else m_cnt--;
      end
      if (tick_i) m_ph = (m_ph + freq) % 65536;
      m_gq = gate_i;
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni || !tick_en) begin
      div <= 0; tick_i <= 1'b0;
    end else begin
      div    <= (div == 3) ? 0 : div + 1;
      tick_i <= (div == 3);
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(cur_req, "left_o", int'(left_o), m_l);
      check(cur_req, "right_o", int'(right_o), m_r);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic set_cfg(logic [15:0] f, logic [7:0] d, logic [7:0] atk,
                         logic [7:0] dcy, logic [7:0] b5, logic [7:0] b6,
                         logic [7:0] b7);
    cfg_i = {b7, b6, b5, dcy, atk, d, f};
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    #(10 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    summary();
  end

  initial begin : stim
    // R1: outputs zero during reset
    set_cfg(16'h0800, 8'd128, 8'h0F, 8'h4C, 8'h00, 8'h00, 8'h00);
    run(3);
    check("R1", "left_o in reset", int'(left_o), 0);
    check("R1", "right_o in reset", int'(right_o), 0);
    rst_ni = 1'b1;
    tick_en = 1'b1;
    run(8);
    check("R1", "left_o idle", int'(left_o), 0);

    // R6 fast attack to level 0, R7 decay to level 4 and hold
    cur_req = "R6"; gate_i = 1'b1; run(400);
    cur_req = "R7"; run(400);

    // R3 all wave shapes
    cur_req = "R3";
    set_cfg(16'h1234, 8'd200, 8'h0F, 8'h4C, 8'h00, 8'h01, 8'h00); run(300);
    set_cfg(16'h1234, 8'd200, 8'h0F, 8'h4C, 8'h00, 8'h02, 8'h00); run(300);
    set_cfg(16'h0F00, 8'd255, 8'h0F, 8'h4C, 8'h00, 8'h03, 8'h00); run(300);

    // R4 duty extremes
    cur_req = "R4";
    set_cfg(16'h1000, 8'd0,   8'h0F, 8'h4C, 8'h00, 8'h00, 8'h00); run(200);
    set_cfg(16'h1000, 8'd0,   8'h0F, 8'h4C, 8'h00, 8'h02, 8'h00); run(200);
    set_cfg(16'h1000, 8'd255, 8'h0F, 8'h4C, 8'h00, 8'h00, 8'h00); run(300);
    set_cfg(16'h1000, 8'd64,  8'h0F, 8'h4C, 8'h00, 8'h01, 8'h00); run(300);

    // R10 pan extremes and off-centre
    cur_req = "R10";
    set_cfg(16'h0C00, 8'd128, 8'h0F, 8'h4C, 8'h40, 8'h01, 8'h00); run(250);
    set_cfg(16'h0C00, 8'd128, 8'h0F, 8'h4C, 8'h3F, 8'h01, 8'h00); run(250);
    set_cfg(16'h0C00, 8'd128, 8'h0F, 8'h4C, 8'h14, 8'h02, 8'h00); run(250);

    // R5 padding and unused bits have no effect
    cur_req = "R5";
    set_cfg(16'h0C00, 8'd128, 8'h0F, 8'h4C, 8'h94, 8'hFE, 8'hA5); run(250);
    set_cfg(16'h0C00, 8'd128, 8'h0F, 8'h4C, 8'h14, 8'h02, 8'h5A); run(250);

    // R8 release to idle at decay rate
    cur_req = "R8"; gate_i = 1'b0; run(900);

    // R9 intermediate attenuations, slow attack rate
    cur_req = "R9";
    set_cfg(16'h0A00, 8'd160, 8'h70, 8'hA3, 8'h00, 8'h00, 8'h00);
    gate_i = 1'b1; run(3000);
    // R8 fall during decay then retrigger during release (R6)
    cur_req = "R8"; gate_i = 1'b0; run(150);
    cur_req = "R6"; gate_i = 1'b1; run(1500);

    // R2 wrap with maximal frequency word, then ticks halted
    cur_req = "R2";
    set_cfg(16'hFFFF, 8'd128, 8'h0F, 8'h4C, 8'h00, 8'h01, 8'h00); run(300);
    set_cfg(16'h8001, 8'd128, 8'h0F, 8'h4C, 8'h00, 8'h02, 8'h00); run(300);
    tick_en = 1'b0; run(100);
    tick_en = 1'b1;

    // R11 abrupt config change lands one cycle later
    cur_req = "R11";
    set_cfg(16'h0400, 8'd128, 8'h0F, 8'h4C, 8'h40, 8'h03, 8'h00); run(1);
    set_cfg(16'h0400, 8'd128, 8'h0F, 8'h4C, 8'h3F, 8'h00, 8'h00); run(1);
    set_cfg(16'h0400, 8'd20,  8'h0F, 8'h4C, 8'h00, 8'h02, 8'h00); run(50);
    gate_i = 1'b0; run(400);

    summary();
  end
endmodule